// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block sits behind a pending-interrupt selector and serves the acknowledge and end-of-interrupt traffic of several processors. For each processor it holds the ID of the interrupt now being serviced and the priority of that service level. It also keeps a chain that links every active interrupt to the one it preempted. An acknowledge takes the selector's best candidate for the requesting processor only if that candidate is strictly more urgent than the running level. When it does, the block emits a pending-clear request and pushes the candidate onto the chain.

An end-of-interrupt names an ID. If that ID is the running one, the chain pops back to its predecessor. If it names an interrupt deeper in the chain, a small walker follows the links one per cycle and splices the completed ID out. The running ID stays where it is. A level-sensitive source whose line is still high is flagged for re-pending through a pending-set request.

The controller has two states. `ST_IDLE` accepts one request per cycle. The transition *start splice* (an out-of-order completion) moves it to `ST_WALK`, which raises `busy` and refuses new requests. Two transitions lead back to `ST_IDLE`: *splice done* (the completed ID was found and unlinked) and *chain end* (the end marker 1023 was reached).

Top module: `ack_eoi_tracker`

## Requirements
- R1: An acknowledge returns ID 1023 and changes no state and requests no pending clear when the selector's ID for that processor is 1023 or its priority is not strictly lower than the processor's running priority.
- R2: A successful acknowledge returns the selector's ID, makes it the running ID and sets the running priority to that ID's priority, one cycle after acceptance.
- R3: A successful acknowledge issues a pending-clear for that ID with a mask holding only the requesting processor's bit (bit n for processor n), or all processor bits when the ID's fan-out-to-all flag is set.
- R4: The running priority reads 0x100 whenever the running ID is 1023; after reset every running ID is 1023 and `busy` is low.
- R5: An end-of-interrupt takes its ID from bits 9:0 of `req_data` and is ignored (no pending-set, no state change, no walk) when the processor's running ID is 1023.
- R6: Completing an ID whose `edge_trig` bit is 0, whose `irq_enable` and `line_level` bits are 1 and whose target bit (index id*NCPU+cpu) is 1 issues a pending-set for that ID with only the completing processor's bit in the mask.
- R7: Completing the running ID makes its recorded predecessor the running ID, with that predecessor's priority.
- R8: Completing a non-running ID leaves the running ID unchanged and removes the completed ID from the chain, so later pops skip it.
- R9: While the splice walk is in progress `busy` is high and requests are not accepted; a held request is served once `busy` falls.
- R10: Each processor's running ID, priority and chain are independent of the others'.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present; accepted when `busy` is low |
| req_eoi | input | 1 | 1 = end-of-interrupt, 0 = acknowledge |
| req_cpu | input | CPU_W | Requesting processor |
| req_data | input | 32 | End-of-interrupt write value (ID in bits 9:0) |
| busy | output | 1 | Splice walk in progress |
| hp_id_flat | input | NCPU*10 | Selector's best pending ID per processor |
| prio_flat | input | NIRQ*PRIO_W | Priority per interrupt ID |
| edge_trig | input | NIRQ | 1 = edge-triggered source |
| fanout_all | input | NIRQ | 1 = acknowledge clears pending for all processors |
| irq_enable | input | NIRQ | Per-ID enable |
| line_level | input | NIRQ | Current input line level |
| target_flat | input | NIRQ*NCPU | Per-ID processor target bits |
| ack_valid | output | 1 | Acknowledge answer pulse |
| ack_id | output | 10 | Acknowledged ID or 1023 |
| clr_valid | output | 1 | Pending-clear request pulse |
| clr_id | output | 10 | ID to clear |
| clr_mask | output | NCPU | Processors to clear |
| set_valid | output | 1 | Pending-set request pulse |
| set_id | output | 10 | ID to re-pend |
| set_mask | output | NCPU | Processor to re-pend |
| run_id_flat | output | NCPU*10 | Running ID per processor |
| run_prio_flat | output | NCPU*(PRIO_W+1) | Running priority per processor |

## Verification
The case that needs care is an acknowledge that arrives while an out-of-order completion is still walking the chain. The bench provokes it by issuing a completion for an ID two links deep, then presenting an acknowledge in the very next cycle while `busy` is still high. It judges the result by seeing that `busy` was observed high, and that the held acknowledge is answered only after the walk ends. The answer must also be measured against the running priority the splice left untouched. The pops that follow must then skip the spliced ID.

// File: rtl/itk_pkg.sv
package itk_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'h3FF;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WALK = 1'b1
    } itk_state_e;
endpackage

// File: rtl/itk_prio_lookup.sv
module itk_prio_lookup
    import itk_pkg::*;
#(
    parameter int NIRQ   = 64,
    parameter int PRIO_W = 8
) (
    input  logic [NIRQ*PRIO_W-1:0] prio_flat,
    input  logic [ID_W-1:0]        id,
    output logic [PRIO_W:0]        prio
);
    // IDs outside the table (including the end marker) rank below every source
    always_comb begin
        if (int'(id) < NIRQ) begin
            prio = {1'b0, prio_flat[int'(id)*PRIO_W +: PRIO_W]};
        end else begin
            prio = {1'b1, {PRIO_W{1'b0}}};
        end
    end
endmodule

// File: rtl/itk_chain_mem.sv
module itk_chain_mem
    import itk_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NIRQ  = 64,
    parameter int CPU_W = 1,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CPU_W-1:0] wr_cpu,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ID_W-1:0]  wr_data,
    input  logic [CPU_W-1:0] rda_cpu,
    input  logic [IDX_W-1:0] rda_idx,
    output logic [ID_W-1:0]  rda_data,
    input  logic [CPU_W-1:0] rdb_cpu,
    input  logic [IDX_W-1:0] rdb_idx,
    output logic [ID_W-1:0]  rdb_data
);
    // predecessor link per processor and per interrupt
    logic [ID_W-1:0] link_q [NCPU][NIRQ];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCPU; c++) begin
                for (int i = 0; i < NIRQ; i++) begin
                    link_q[c][i] <= ID_NONE;
                end
            end
        end else if (wr_en) begin
            link_q[wr_cpu][wr_idx] <= wr_data;
        end
    end

    assign rda_data = link_q[rda_cpu][rda_idx];
    assign rdb_data = link_q[rdb_cpu][rdb_idx];
endmodule

// File: rtl/itk_reinstate.sv
module itk_reinstate
    import itk_pkg::*;
#(
    parameter int NCPU  = 2,
    parameter int NIRQ  = 64,
    parameter int CPU_W = 1
) (
    input  logic [ID_W-1:0]       id,
    input  logic [CPU_W-1:0]      cpu,
    input  logic [NIRQ-1:0]       edge_trig,
    input  logic [NIRQ-1:0]       irq_enable,
    input  logic [NIRQ-1:0]       line_level,
    input  logic [NIRQ*NCPU-1:0]  target_flat,
    output logic                  hit
);
    always_comb begin
        hit = 1'b0;
        if (int'(id) < NIRQ) begin
            hit = !edge_trig[id] && irq_enable[id] && line_level[id]
                  && target_flat[int'(id)*NCPU + int'(cpu)];
        end
    end
endmodule

// File: rtl/ack_eoi_tracker.sv
module ack_eoi_tracker
    import itk_pkg::*;
#(
    parameter int NCPU   = 2,
    parameter int NIRQ   = 64,
    parameter int PRIO_W = 8,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int IDX_W = $clog2(NIRQ)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_eoi,
    input  logic [CPU_W-1:0]         req_cpu,
    input  logic [31:0]              req_data,
    output logic                     busy,
    input  logic [NCPU*ID_W-1:0]     hp_id_flat,
    input  logic [NIRQ*PRIO_W-1:0]   prio_flat,
    input  logic [NIRQ-1:0]          edge_trig,
    input  logic [NIRQ-1:0]          fanout_all,
    input  logic [NIRQ-1:0]          irq_enable,
    input  logic [NIRQ-1:0]          line_level,
    input  logic [NIRQ*NCPU-1:0]     target_flat,
    output logic                     ack_valid,
    output logic [ID_W-1:0]          ack_id,
    output logic                     clr_valid,
    output logic [ID_W-1:0]          clr_id,
    output logic [NCPU-1:0]          clr_mask,
    output logic                     set_valid,
    output logic [ID_W-1:0]          set_id,
    output logic [NCPU-1:0]          set_mask,
    output logic [NCPU*ID_W-1:0]     run_id_flat,
    output logic [NCPU*(PRIO_W+1)-1:0] run_prio_flat
);
    localparam logic [PRIO_W:0] PRIO_IDLE = {1'b1, {PRIO_W{1'b0}}};

    itk_state_e state_q, state_d;

    logic [ID_W-1:0]  run_id_q   [NCPU];
    logic [PRIO_W:0]  run_prio_q [NCPU];
    logic [CPU_W-1:0] walk_cpu_q;
    logic [ID_W-1:0]  walk_id_q;
    logic [ID_W-1:0]  walk_ptr_q;

    logic             accept;
    logic [ID_W-1:0]  cur_run, cur_hp, eoi_id;
    logic [PRIO_W:0]  hp_prio, pop_prio;
    logic             ack_ok, reinst_hit;
    logic [ID_W-1:0]  rda_data, rdb_data;
    logic [CPU_W-1:0] rda_cpu;
    logic [IDX_W-1:0] rda_idx;
    logic             walk_end, walk_hit;
    logic             mem_we;
    logic [CPU_W-1:0] mem_wcpu;
    logic [IDX_W-1:0] mem_widx;
    logic [ID_W-1:0]  mem_wdata;
    logic [31-ID_W:0] unused_hi;

    assign unused_hi = req_data[31:ID_W];
    assign busy      = (state_q == ST_WALK);
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign cur_run   = run_id_q[req_cpu];
    assign cur_hp    = hp_id_flat[int'(req_cpu)*ID_W +: ID_W];
    assign eoi_id    = req_data[ID_W-1:0];
    assign ack_ok    = (cur_hp != ID_NONE) && (hp_prio < run_prio_q[req_cpu]);

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_flat
            assign run_id_flat[c*ID_W +: ID_W]           = run_id_q[c];
            assign run_prio_flat[c*(PRIO_W+1) +: PRIO_W+1] = run_prio_q[c];
        end
    endgenerate

    itk_prio_lookup #(.NIRQ(NIRQ), .PRIO_W(PRIO_W)) u_hp_prio (
        .prio_flat(prio_flat), .id(cur_hp), .prio(hp_prio)
    );
    itk_prio_lookup #(.NIRQ(NIRQ), .PRIO_W(PRIO_W)) u_pop_prio (
        .prio_flat(prio_flat), .id(rda_data), .prio(pop_prio)
    );
    itk_reinstate #(.NCPU(NCPU), .NIRQ(NIRQ), .CPU_W(CPU_W)) u_reinst (
        .id(eoi_id), .cpu(req_cpu), .edge_trig(edge_trig),
        .irq_enable(irq_enable), .line_level(line_level),
        .target_flat(target_flat), .hit(reinst_hit)
    );

    // port A: predecessor of the running ID in idle, of the walk pointer in walk
    assign rda_cpu  = busy ? walk_cpu_q : req_cpu;
    assign rda_idx  = busy ? walk_ptr_q[IDX_W-1:0] : cur_run[IDX_W-1:0];
    assign walk_end = busy && (rda_data == ID_NONE);
    assign walk_hit = busy && !walk_end && (rda_data == walk_id_q);

    always_comb begin
        mem_we    = 1'b0;
        mem_wcpu  = req_cpu;
        mem_widx  = cur_hp[IDX_W-1:0];
        mem_wdata = cur_run;
        if (busy) begin
            mem_we    = walk_hit;
            mem_wcpu  = walk_cpu_q;
            mem_widx  = walk_ptr_q[IDX_W-1:0];
            mem_wdata = rdb_data;
        end else if (accept && !req_eoi && ack_ok) begin
            mem_we = 1'b1;
        end
    end

    itk_chain_mem #(.NCPU(NCPU), .NIRQ(NIRQ), .CPU_W(CPU_W), .IDX_W(IDX_W)) u_chain (
        .clk(clk), .rst_n(rst_n),
        .wr_en(mem_we), .wr_cpu(mem_wcpu), .wr_idx(mem_widx), .wr_data(mem_wdata),
        .rda_cpu(rda_cpu), .rda_idx(rda_idx), .rda_data(rda_data),
        .rdb_cpu(walk_cpu_q), .rdb_idx(walk_id_q[IDX_W-1:0]), .rdb_data(rdb_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start splice, splice done, chain end
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (accept && req_eoi && cur_run != ID_NONE && eoi_id != cur_run)
                         state_d = ST_WALK;
            ST_WALK: if (walk_end || walk_hit)
                         state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs and per-processor state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCPU; c++) begin
                run_id_q[c]   <= ID_NONE;
                run_prio_q[c] <= PRIO_IDLE;
            end
            walk_cpu_q <= '0;
            walk_id_q  <= ID_NONE;
            walk_ptr_q <= ID_NONE;
            ack_valid  <= 1'b0;
            ack_id     <= ID_NONE;
            clr_valid  <= 1'b0;
            clr_id     <= ID_NONE;
            clr_mask   <= '0;
            set_valid  <= 1'b0;
            set_id     <= ID_NONE;
            set_mask   <= '0;
        end else begin
            ack_valid <= 1'b0;
            clr_valid <= 1'b0;
            set_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept && !req_eoi) begin
                        ack_valid <= 1'b1;
                        ack_id    <= ack_ok ? cur_hp : ID_NONE;
                        if (ack_ok) begin
                            run_id_q[req_cpu]   <= cur_hp;
                            run_prio_q[req_cpu] <= hp_prio;
                            clr_valid <= 1'b1;
                            clr_id    <= cur_hp;
                            clr_mask  <= fanout_all[cur_hp[IDX_W-1:0]]
                                         ? {NCPU{1'b1}} : NCPU'(1) << req_cpu;
                        end
                    end else if (accept && req_eoi && cur_run != ID_NONE) begin
                        if (reinst_hit) begin
                            set_valid <= 1'b1;
                            set_id    <= eoi_id;
                            set_mask  <= NCPU'(1) << req_cpu;
                        end
                        if (eoi_id == cur_run) begin
                            run_id_q[req_cpu]   <= rda_data;
                            run_prio_q[req_cpu] <= pop_prio;
                        end else begin
                            walk_cpu_q <= req_cpu;
                            walk_id_q  <= eoi_id;
                            walk_ptr_q <= cur_run;
                        end
                    end
                end
                ST_WALK: begin
                    if (!walk_end && !walk_hit) walk_ptr_q <= rda_data;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/itk_tracker_chk.sv
module itk_tracker_chk
    import itk_pkg::*;
#(
    parameter int NCPU   = 2,
    parameter int NIRQ   = 64,
    parameter int PRIO_W = 8,
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_eoi,
    input logic [CPU_W-1:0]           req_cpu,
    input logic                       busy,
    input logic [NCPU*ID_W-1:0]       hp_id_flat,
    input logic                       ack_valid,
    input logic [ID_W-1:0]            ack_id,
    input logic                       clr_valid,
    input logic [ID_W-1:0]            clr_id,
    input logic [NCPU-1:0]            clr_mask,
    input logic                       set_valid,
    input logic [NCPU-1:0]            set_mask,
    input logic [NCPU*ID_W-1:0]       run_id_flat,
    input logic [NCPU*(PRIO_W+1)-1:0] run_prio_flat
);
    logic [ID_W-1:0] sel_hp, sel_run;
    assign sel_hp  = hp_id_flat[int'(req_cpu)*ID_W +: ID_W];
    assign sel_run = run_id_flat[int'(req_cpu)*ID_W +: ID_W];

    AST_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !req_eoi && sel_hp == ID_NONE)
        |=> (ack_valid && ack_id == ID_NONE && !clr_valid)); // R1

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_id != ID_NONE) |-> (clr_valid && clr_id == ack_id)); // R2

    AST_CLR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid |-> ($onehot(clr_mask) || clr_mask == {NCPU{1'b1}})); // R3

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_idle
            AST_IDLE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
                (run_id_flat[c*ID_W +: ID_W] == ID_NONE)
                |-> (run_prio_flat[c*(PRIO_W+1) +: PRIO_W+1] == {1'b1, {PRIO_W{1'b0}}})); // R4
        end
    endgenerate

    AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_eoi && sel_run == ID_NONE)
        |=> (!set_valid && !busy && $stable(run_id_flat))); // R5

    AST_SET_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        set_valid |-> $onehot(set_mask)); // R6

    AST_WALK_RUN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(run_id_flat)); // R8

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!ack_valid && !clr_valid)); // R9
endmodule

bind ack_eoi_tracker itk_tracker_chk #(.NCPU(NCPU), .NIRQ(NIRQ), .PRIO_W(PRIO_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_eoi(req_eoi),
    .req_cpu(req_cpu), .busy(busy), .hp_id_flat(hp_id_flat),
    .ack_valid(ack_valid), .ack_id(ack_id), .clr_valid(clr_valid),
    .clr_id(clr_id), .clr_mask(clr_mask), .set_valid(set_valid),
    .set_mask(set_mask), .run_id_flat(run_id_flat), .run_prio_flat(run_prio_flat)
);

// File: tb/ack_eoi_tracker_tb.sv
module ack_eoi_tracker_tb;
    localparam int NCPU = 2;
    localparam int NIRQ = 64;
    localparam int PW   = 8;
    localparam logic [9:0] NONE = 10'h3FF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_eoi = 1'b0;
    logic [0:0] req_cpu = '0;
    logic [31:0] req_data = '0;
    logic busy;
    logic [NCPU*10-1:0] hp_id_flat = {NONE, NONE};
    logic [NIRQ*PW-1:0] prio_flat = '1;
    logic [NIRQ-1:0] edge_trig = '1, fanout_all = '0, irq_enable = '0, line_level = '0;
    logic [NIRQ*NCPU-1:0] target_flat = '0;
    logic ack_valid, clr_valid, set_valid;
    logic [9:0] ack_id, clr_id, set_id;
    logic [NCPU-1:0] clr_mask, set_mask;
    logic [NCPU*10-1:0] run_id_flat;
    logic [NCPU*(PW+1)-1:0] run_prio_flat;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    // captured outputs of the last request
    logic c_ack_v, c_clr_v, c_set_v, c_busy_seen;
    logic [9:0] c_ack_id, c_clr_id, c_set_id;
    logic [NCPU-1:0] c_clr_mask, c_set_mask;

    always #10ns clk = ~clk;

    ack_eoi_tracker #(.NCPU(NCPU), .NIRQ(NIRQ), .PRIO_W(PW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_eoi(req_eoi),
        .req_cpu(req_cpu), .req_data(req_data), .busy(busy),
        .hp_id_flat(hp_id_flat), .prio_flat(prio_flat), .edge_trig(edge_trig),
        .fanout_all(fanout_all), .irq_enable(irq_enable), .line_level(line_level),
        .target_flat(target_flat), .ack_valid(ack_valid), .ack_id(ack_id),
        .clr_valid(clr_valid), .clr_id(clr_id), .clr_mask(clr_mask),
        .set_valid(set_valid), .set_id(set_id), .set_mask(set_mask),
        .run_id_flat(run_id_flat), .run_prio_flat(run_prio_flat)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [9:0] run_of(input int c);
        return run_id_flat[c*10 +: 10];
    endfunction
    function automatic logic [8:0] prio_of(input int c);
        return run_prio_flat[c*9 +: 9];
    endfunction

    task automatic set_prio(input int id, input logic [7:0] p);
        prio_flat[id*PW +: PW] = p;
    endtask

    // present a request, hold it while busy, capture the pulses after acceptance
    task automatic issue(input bit eoi, input int cpu, input logic [31:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_eoi = eoi; req_cpu = 1'(cpu); req_data = data;
        c_busy_seen = busy;
        while (busy) @(negedge clk);
        @(negedge clk);
        c_ack_v = ack_valid; c_ack_id = ack_id;
        c_clr_v = clr_valid; c_clr_id = clr_id; c_clr_mask = clr_mask;
        c_set_v = set_valid; c_set_id = set_id; c_set_mask = set_mask;
        req_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R4 run0 after reset", 32'(run_of(0)), 32'(NONE));
        check("R4 run1 after reset", 32'(run_of(1)), 32'(NONE));
        check("R4 prio0 after reset", 32'(prio_of(0)), 32'h100);
        check("R4 busy after reset", 32'(busy), 0);
    endtask

    task automatic t_spurious;
        hp_id_flat[9:0] = NONE;
        issue(1'b0, 0, 0);
        check("R1 ack with no pending", 32'(c_ack_id), 32'(NONE));
        check("R1 no clear", 32'(c_clr_v), 0);
        issue(1'b1, 0, 32'd5);
        check("R5 eoi while idle no set", 32'(c_set_v), 0);
        check("R5 eoi while idle run0", 32'(run_of(0)), 32'(NONE));
        check("R5 eoi while idle busy", 32'(busy), 0);
    endtask

    task automatic t_nest;
        hp_id_flat[9:0] = 10'd5;
        issue(1'b0, 0, 0);
        check("R2 ack id 5", 32'(c_ack_id), 5);
        check("R2 run0 is 5", 32'(run_of(0)), 5);
        check("R2 prio0 is 0x80", 32'(prio_of(0)), 32'h080);
        check("R3 clear mask own cpu", 32'(c_clr_mask), 32'b01);
        issue(1'b0, 0, 0);
        check("R1 equal priority refused", 32'(c_ack_id), 32'(NONE));
        check("R1 equal priority run0", 32'(run_of(0)), 5);
        hp_id_flat[9:0] = 10'd6;
        issue(1'b0, 0, 0);
        check("R2 nested ack 6", 32'(c_ack_id), 6);
        hp_id_flat[9:0] = 10'd7;
        issue(1'b0, 0, 0);
        check("R2 nested ack 7", 32'(c_ack_id), 7);
        check("R3 fan-out clear mask all", 32'(c_clr_mask), 32'b11);
        check("R3 clear id 7", 32'(c_clr_id), 7);
    endtask

    task automatic t_splice_stall;
        // upper bits noise must be dropped: ID 5 from bits 9:0
        issue(1'b1, 0, 32'hABCD_FC05);
        check("R8 splice keeps run0", 32'(run_of(0)), 7);
        check("R9 busy during walk", 32'(busy), 1);
        hp_id_flat[9:0] = 10'd40;     // priority 0x60, not above running 0x20
        issue(1'b0, 0, 0);
        check("R9 ack was held while busy", 32'(c_busy_seen), 1);
        check("R9 held ack answered 1023", 32'(c_ack_id), 32'(NONE));
        check("R9 held ack answered", 32'(c_ack_v), 1);
        issue(1'b1, 0, 32'd7);
        check("R7 pop to 6", 32'(run_of(0)), 6);
        check("R7 prio 0x40", 32'(prio_of(0)), 32'h040);
        issue(1'b1, 0, 32'd6);
        check("R8 pop skips spliced 5", 32'(run_of(0)), 32'(NONE));
        check("R4 prio idle after pop", 32'(prio_of(0)), 32'h100);
    endtask

    task automatic t_level_cpu1;
        hp_id_flat[9:0] = 10'd6;
        issue(1'b0, 0, 0);
        hp_id_flat[19:10] = 10'd40;
        issue(1'b0, 1, 0);
        check("R10 cpu1 ack 40", 32'(c_ack_id), 40);
        check("R3 cpu1 clear mask", 32'(c_clr_mask), 32'b10);
        check("R10 cpu0 still 6", 32'(run_of(0)), 6);
        issue(1'b1, 1, 32'd40);
        check("R6 reinstate set", 32'(c_set_v), 1);
        check("R6 reinstate id", 32'(c_set_id), 40);
        check("R6 reinstate mask", 32'(c_set_mask), 32'b10);
        check("R10 cpu1 idle", 32'(run_of(1)), 32'(NONE));
        check("R10 cpu0 untouched", 32'(run_of(0)), 6);
        line_level[40] = 1'b0;
        issue(1'b0, 1, 0);
        issue(1'b1, 1, 32'd40);
        check("R6 low line no set", 32'(c_set_v), 0);
    endtask

    initial begin
        set_prio(5, 8'h80); set_prio(6, 8'h40); set_prio(7, 8'h20); set_prio(40, 8'h60);
        fanout_all[7] = 1'b1;
        edge_trig[40] = 1'b0; irq_enable[40] = 1'b1; line_level[40] = 1'b1;
        target_flat[40*NCPU + 0] = 1'b1; target_flat[40*NCPU + 1] = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_spurious;
        t_nest;
        t_splice_stall;
        t_level_cpu1;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule